// File: doc/BRIEF.md
# Timer Capture/Compare Status Flags

One timer channel with a free-running up counter and two general registers, B and C. Each general register works either as a compare register, where its flag sets when the counter equals it, or as a capture register, where a rising edge on its capture input copies the counter into it and sets its flag. The flags sit in a status register that software clears through a two-step handshake: the flag must first be read as 1, and then a 0 must be written to that bit. A level interrupt request combines the flags with per-flag enables.

A build parameter removes the C resources for reduced channels. The C flag position then reads 0 and ignores writes, and register C, its mode bit and its enable bit are absent. The block sits on a simple single-cycle register bus. Reads are combinational in the cycle where the select is high. Writes take effect at the clock edge that ends that cycle.

Top module: `tmr_cc_flags`

## Requirements
- R1: While reset is asserted and right after it is released, the control, status, counter and both general registers read 0.
- R2: With a register in compare mode (control bit 0 for B, bit 1 for C, value 0 = compare), its flag is 1 from the cycle after the cycle in which the counter equals that register.
- R3: In capture mode (control mode bit = 1), a rising edge on the capture input passes through a two-flop synchronizer and an edge detector. The register takes the counter value of the cycle in which the edge is detected, and its flag sets, three clock edges after the input rises.
- R4: A status (offset 1, B at bit 0, C at bit 1) write of 0 clears a flag only when that flag returned 1 on an earlier status read with no status write in between. Otherwise the flag is unchanged.
- R5: Writing 1 to a status bit never sets or clears a flag.
- R6: Every status write uses up the read-as-1 arming of both flags, whatever value is written. A later write of 0 with no new read has no effect.
- R7: If a set event and a qualifying clear fall in the same cycle, the flag stays 1.
- R8: The interrupt request is the OR of each flag ANDed with its enable (control bit 2 for B, bit 3 for C). It goes low in the cycle after a clear that removes the last enabled flag.
- R9: With the C resources absent, status bit 1, control bits 1 and 3, and register C (offset 4) always read 0, and writes to them have no effect.
- R10: The counter (offset 2) increments by 1 every cycle. A bus write loads it, and it continues counting from the loaded value. Register B is at offset 3 and control is at offset 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_b_in | input | 1 | Asynchronous capture input for register B |
| cap_c_in | input | 1 | Asynchronous capture input for register C |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, valid while bus_sel is high for a read |
| irq | output | 1 | Level interrupt request |

## Verification
A faulty arming bit shows up as a flag that clears on a bare write of 0, or that survives a correct read-then-write. Either case is visible on the next status read, and on irq in the very next cycle. A wrong set/clear priority leaves the flag at 0 right after a write that coincides with a compare match. An extra or missing synchronizer stage moves the captured counter value by one count, so the register read-back exposes it. A missing mask on the reduced channel appears directly in the read data of status bit 1, control, or offset 4.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd1;
   localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd2;
   localparam logic [ADDR_W-1:0] ADDR_GRB  = 3'd3;
   localparam logic [ADDR_W-1:0] ADDR_GRC  = 3'd4;

   // bit 0 = mode B, bit 1 = mode C, bit 2 = enable B, bit 3 = enable C
   typedef struct packed {
      logic ien_c;
      logic ien_b;
      logic mode_c;
      logic mode_b;
   } ctrl_t;
endpackage

// File: rtl/tmr_cc_edge.sv
module tmr_cc_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [SYNC_STAGES:0] sh_q;

   initial begin
      if (SYNC_STAGES < 2) $fatal(1, "tmr_cc_edge: SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-1:0], din};
   end

   assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/tmr_cc_res.sv
module tmr_cc_res #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             mode_cap,
   input  logic             cap_rise,
   input  logic             gr_wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             st_rd,
   input  logic             st_wr,
   input  logic             st_bit,
   output logic [CNT_W-1:0] gr,
   output logic             flag
);
   logic arm_q;
   logic set_ev;

   assign set_ev = mode_cap ? cap_rise : (cnt == gr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gr    <= '0;
         flag  <= 1'b0;
         arm_q <= 1'b0;
      end else begin
         if (mode_cap && cap_rise) gr <= cnt;
         else if (gr_wr)           gr <= wdata;

         if (set_ev)                          flag <= 1'b1;
         else if (st_wr && arm_q && !st_bit)  flag <= 1'b0;

         if (st_wr)              arm_q <= 1'b0;
         else if (st_rd && flag) arm_q <= 1'b1;
      end
   end
endmodule

// File: rtl/tmr_cc_flags.sv
module tmr_cc_flags
   import tmr_cc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter bit HAS_C       = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_b_in,
   input  logic             cap_c_in,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             irq
);
   localparam logic [3:0] CTRL_MASK = HAS_C ? 4'hF : 4'h5;

   initial begin
      if (CNT_W < 8)  $fatal(1, "tmr_cc_flags: CNT_W must be at least 8");
      if (CNT_W > 32) $fatal(1, "tmr_cc_flags: CNT_W must not exceed 32");
   end

   logic             rd_en, wr_en, st_rd, st_wr;
   logic [CNT_W-1:0] cnt_q;
   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] gr_b, gr_c;
   logic             flag_b, flag_c;
   logic             rise_b;

   assign rd_en = bus_sel & ~bus_wr;
   assign wr_en = bus_sel &  bus_wr;
   assign st_rd = rd_en && (bus_addr == ADDR_STAT);
   assign st_wr = wr_en && (bus_addr == ADDR_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_en && bus_addr == ADDR_CNT) cnt_q <= bus_wdata;
         else                               cnt_q <= cnt_q + 1'b1;
         if (wr_en && bus_addr == ADDR_CTRL)
            ctrl_q <= ctrl_t'(bus_wdata[3:0] & CTRL_MASK);
      end
   end

   tmr_cc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_b (
      .clk(clk), .rst_n(rst_n), .din(cap_b_in), .rise(rise_b)
   );

   tmr_cc_res #(.CNT_W(CNT_W)) u_res_b (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q),
      .mode_cap(ctrl_q.mode_b), .cap_rise(rise_b),
      .gr_wr(wr_en && bus_addr == ADDR_GRB), .wdata(bus_wdata),
      .st_rd(st_rd), .st_wr(st_wr), .st_bit(bus_wdata[0]),
      .gr(gr_b), .flag(flag_b)
   );

   generate
      if (HAS_C) begin : g_c
         logic rise_c;
         tmr_cc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_c (
            .clk(clk), .rst_n(rst_n), .din(cap_c_in), .rise(rise_c)
         );
         tmr_cc_res #(.CNT_W(CNT_W)) u_res_c (
            .clk(clk), .rst_n(rst_n), .cnt(cnt_q),
            .mode_cap(ctrl_q.mode_c), .cap_rise(rise_c),
            .gr_wr(wr_en && bus_addr == ADDR_GRC), .wdata(bus_wdata),
            .st_rd(st_rd), .st_wr(st_wr), .st_bit(bus_wdata[1]),
            .gr(gr_c), .flag(flag_c)
         );
      end else begin : g_no_c
         assign gr_c   = '0;
         assign flag_c = 1'b0;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         case (bus_addr)
            ADDR_CTRL: bus_rdata[3:0] = ctrl_q;
            ADDR_STAT: bus_rdata[1:0] = {flag_c, flag_b};
            ADDR_CNT:  bus_rdata      = cnt_q;
            ADDR_GRB:  bus_rdata      = gr_b;
            ADDR_GRC:  bus_rdata      = gr_c;
            default:   bus_rdata      = '0;
         endcase
      end
   end

   assign irq = (flag_b & ctrl_q.ien_b) | (flag_c & ctrl_q.ien_c);
endmodule

// File: rtl/tmr_cc_flags_chk.sv
module tmr_cc_flags_chk
   import tmr_cc_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter bit HAS_C = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [2:0]       bus_addr,
   input logic [CNT_W-1:0] bus_wdata,
   input logic [CNT_W-1:0] bus_rdata,
   input logic             irq,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] gr_b,
   input logic             flag_b,
   input logic             mode_b,
   input logic             cap_rise_b
);
   AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_b && cnt == gr_b) |=> flag_b); // R2

   AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_b && cap_rise_b) |=> (flag_b && gr_b == $past(cnt))); // R3

   AST_CLR_NEEDS_WR0: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_b) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_STAT && !bus_wdata[0])); // R4

   AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_b && (mode_b ? !cap_rise_b : cnt != gr_b)) |=> !flag_b); // R5

   AST_IRQ_FALL_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_sel && bus_wr)); // R8

   AST_C_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (!HAS_C && bus_sel && !bus_wr && bus_addr == ADDR_STAT) |-> !bus_rdata[1]); // R9
endmodule

bind tmr_cc_flags tmr_cc_flags_chk #(.CNT_W(CNT_W), .HAS_C(HAS_C)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .irq(irq), .cnt(cnt_q), .gr_b(gr_b), .flag_b(flag_b),
   .mode_b(ctrl_q.mode_b), .cap_rise_b(rise_b)
);

// File: tb/tmr_cc_flags_tb_top.sv
module tmr_cc_flags_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_b_in = 1'b0;
   logic        cap_c_in = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] rdata_f, rdata_r;
   logic        irq_f, irq_r;
   int          n_chk = 0;
   int          n_err = 0;

   always #5 clk = ~clk;

   tmr_cc_flags #(.CNT_W(16), .HAS_C(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cap_b_in(cap_b_in), .cap_c_in(cap_c_in),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_f), .irq(irq_f)
   );

   tmr_cc_flags #(.CNT_W(16), .HAS_C(1'b0)) dut_r (
      .clk(clk), .rst_n(rst_n), .cap_b_in(cap_b_in), .cap_c_in(cap_c_in),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_r), .irq(irq_r)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] df, output logic [15:0] dr);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1; df = rdata_f; dr = rdata_r;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic clear_all();
      logic [15:0] f, r;
      rd(3'd1, f, r);
      wr(3'd1, 16'h0);
   endtask

   task automatic set_flag_b();
      wr(3'd3, 16'h0500);
      wr(3'd2, 16'h0500);
      repeat (2) @(posedge clk);
      #1 wr(3'd3, 16'hF000);
   endtask

   task automatic set_flag_c();
      wr(3'd4, 16'h0600);
      wr(3'd2, 16'h0600);
      repeat (2) @(posedge clk);
      #1 wr(3'd4, 16'hF000);
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 status in reset", rdata_f, 16'h0);
      rst_n = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b0;
      bus_addr = 3'd1; #1 check("R1 status", rdata_f, 16'h0);
      bus_addr = 3'd0; #1 check("R1 control", rdata_f, 16'h0);
      bus_addr = 3'd2; #1 check("R1 counter", rdata_f, 16'h0);
      bus_addr = 3'd3; #1 check("R1 reg B", rdata_f, 16'h0);
      bus_addr = 3'd4; #1 check("R1 reg C", rdata_f, 16'h0);
      bus_sel = 1'b0;
   endtask

   task automatic t_initial_match();
      logic [15:0] f, r;
      wr(3'd3, 16'hF000);
      wr(3'd4, 16'hF000);
      rd(3'd1, f, r);
      check("R2 zero match after reset", f, 16'h0003);
      wr(3'd1, 16'h0);
      rd(3'd1, f, r);
      check("R4 read-then-write0 clears", f, 16'h0000);
   endtask

   task automatic t_counter();
      logic [15:0] f, r;
      wr(3'd2, 16'h1234);
      rd(3'd2, f, r);
      check("R10 counter load", f, 16'h1234);
      rd(3'd2, f, r);
      check("R10 counter increments", f, 16'h1235);
   endtask

   task automatic t_compare();
      logic [15:0] f, r;
      clear_all();
      wr(3'd3, 16'h0300);
      wr(3'd2, 16'h02F0);
      repeat (8) @(posedge clk);
      rd(3'd1, f, r);
      check("R2 before match", f, 16'h0000);
      repeat (10) @(posedge clk);
      rd(3'd1, f, r);
      check("R2 after match B only", f, 16'h0001);
      wr(3'd3, 16'hF000);
      clear_all();
   endtask

   task automatic t_clear_handshake();
      logic [15:0] f, r;
      clear_all();
      set_flag_b();
      wr(3'd1, 16'h0);
      rd(3'd1, f, r);
      check("R4 write0 without read ignored", f, 16'h0001);
      wr(3'd1, 16'h0);
      rd(3'd1, f, r);
      check("R4 write0 after read clears", f, 16'h0000);
   endtask

   task automatic t_write_one();
      logic [15:0] f, r;
      clear_all();
      wr(3'd1, 16'h0003);
      rd(3'd1, f, r);
      check("R5 write1 does not set", f, 16'h0000);
   endtask

   task automatic t_arm_consumed();
      logic [15:0] f, r;
      clear_all();
      set_flag_b();
      set_flag_c();
      rd(3'd1, f, r);
      check("R6 both set", f, 16'h0003);
      wr(3'd1, 16'h0002);
      rd(3'd1, f, r);
      check("R5 write1 keeps C", f, 16'h0002);
      wr(3'd1, 16'h0003);
      wr(3'd1, 16'h0000);
      rd(3'd1, f, r);
      check("R6 arm consumed by write", f, 16'h0002);
      clear_all();
   endtask

   task automatic t_set_wins();
      logic [15:0] f, r;
      clear_all();
      set_flag_b();
      wr(3'd3, 16'h0700);
      rd(3'd1, f, r);
      check("R7 armed read", f, 16'h0001);
      wr(3'd2, 16'h0700);
      wr(3'd1, 16'h0000);
      rd(3'd1, f, r);
      check("R7 set wins over clear", f, 16'h0001);
      wr(3'd3, 16'hF000);
      clear_all();
      rd(3'd1, f, r);
      check("R7 later clear works", f, 16'h0000);
   endtask

   task automatic t_irq();
      logic [15:0] f, r;
      wr(3'd0, 16'h0004);
      clear_all();
      check("R8 idle irq", {15'h0, irq_f}, 16'h0);
      set_flag_c();
      check("R8 disabled flag no irq", {15'h0, irq_f}, 16'h0);
      set_flag_b();
      check("R8 enabled flag irq", {15'h0, irq_f}, 16'h1);
      rd(3'd1, f, r);
      @(negedge clk);
      check("R8 irq before clear", {15'h0, irq_f}, 16'h1);
      wr(3'd1, 16'h0);
      check("R8 irq low after clear", {15'h0, irq_f}, 16'h0);
      wr(3'd0, 16'h0000);
   endtask

   task automatic t_capture();
      logic [15:0] f, r;
      clear_all();
      wr(3'd0, 16'h0005);
      wr(3'd2, 16'h1000);
      cap_b_in = 1'b1;
      @(posedge clk); #1;
      @(posedge clk); #1;
      check("R3 flag not yet", {15'h0, irq_f}, 16'h0);
      @(posedge clk); #1;
      check("R3 flag on third edge", {15'h0, irq_f}, 16'h1);
      rd(3'd3, f, r);
      check("R3 captured value", f, 16'h1002);
      cap_b_in = 1'b0;
      wr(3'd3, 16'hF000);
      wr(3'd0, 16'h0000);
      clear_all();
   endtask

   task automatic t_reduced();
      logic [15:0] f, r;
      clear_all();
      set_flag_c();
      rd(3'd1, f, r);
      check("R9 full channel C flag", f, 16'h0002);
      check("R9 reduced C flag reads 0", r, 16'h0000);
      wr(3'd4, 16'h0ABC);
      rd(3'd4, f, r);
      check("R9 full reg C", f, 16'h0ABC);
      check("R9 reduced reg C reads 0", r, 16'h0000);
      wr(3'd0, 16'h000A);
      rd(3'd0, f, r);
      check("R9 full control", f, 16'h000A);
      check("R9 reduced control C bits 0", r, 16'h0000);
      wr(3'd0, 16'h0000);
      wr(3'd4, 16'hF000);
      clear_all();
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_initial_match();
      t_counter();
      t_compare();
      t_clear_handshake();
      t_write_one();
      t_arm_consumed();
      t_set_wins();
      t_irq();
      t_capture();
      t_reduced();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule